// File: doc/BRIEF.md
# PWM Output Override Unit

This block sits between a six-channel PWM generator and the output pins. For each channel it picks either the generator waveform or a static level held in software-written registers, so firmware can take manual control of chosen outputs, for instance to step a six-step brushless motor commutation while the remaining channels keep their duty-cycle drive.

Two 8-bit registers are written through a synchronous strobe with a 1-bit address. The select register (address 0) holds one bit per channel: 1 hands the channel to the generator, 0 hands it to the manual level. The level register (address 1) holds one bit per channel: the static value used when the channel is under manual control. A complementary-pairing input makes each even output the inverse of its odd partner, whatever the even channel's own bits hold. All six outputs are registered, so both paths have one cycle of latency and a register write shows on the pins one edge after it.

Top module: `pwm_ovr_unit`

## Requirements
- R1: After reset, the select register reads 0x3F and the level register reads 0x00, so every output follows the generator.
- R2: With select bit i = 1 and complementary mode off, out_pwm[i] equals gen_pwm[i] sampled at the previous clock edge.
- R3: With select bit i = 0 and complementary mode off, out_pwm[i] equals level bit i as held at the previous clock edge (1 = active = logic 1).
- R4: A write (wr_en = 1, wr_addr 0 = select, 1 = level) loads wr_data[5:0] at that edge; bits 7:6 of both registers are always read back as 0 whatever is written.
- R5: rd_data returns the register picked by rd_addr combinationally (0 = select, 1 = level).
- R6: With comp_mode = 1, for each pair k in 0..2, out_pwm[2k] equals the inverse of out_pwm[2k+1], and the odd output follows R2/R3 rules; the even channel's own select and level bits have no effect.
- R7: A write changes the outputs at the very next clock edge after the write edge, with no wait for a PWM period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 select, 1 level |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address: 0 select, 1 level |
| rd_data | output | 8 | Read data of addressed register |
| comp_mode | input | 1 | Complementary pairing enable |
| gen_pwm | input | 6 | Generator waveforms, one per channel |
| out_pwm | output | 6 | Registered output pins |

## Verification
A register write and an output update can fall in the same cycle: the write lands at one edge while the pins are sampled from the old register value at that same edge, and the new value shows only one edge later. The bench provokes this by writing random select and level values on many consecutive cycles while the generator inputs and the complementary flag also change every cycle, and a bench model that tracks the registers one edge behind predicts each output. Directed cases then write conflicting even-channel bits under complementary mode to show they have no effect.

// File: rtl/pwm_ovr_pkg.sv
// Package: shared widths and register addresses for the override unit.
// Assumes six channels arranged as three even/odd pairs.
package pwm_ovr_pkg;
    localparam int NUM_CH   = 6;
    localparam int REG_W    = 8;
    localparam int NUM_PAIR = NUM_CH / 2;
    localparam logic ADDR_SEL = 1'b0;
    localparam logic ADDR_LVL = 1'b1;
    typedef logic [NUM_CH-1:0] ch_vec_t;
endpackage

// File: rtl/pwm_ovr_regs.sv
// Module: holds the select and level registers and serves reads.
// Assumes synchronous active-low reset; unused upper bits read as 0.
module pwm_ovr_regs
    import pwm_ovr_pkg::*;
#(
    parameter int CH = NUM_CH,
    parameter int RW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_addr,
    input  logic [RW-1:0] wr_data,
    input  logic          rd_addr,
    output logic [RW-1:0] rd_data,
    output logic [CH-1:0] sel_q,
    output logic [CH-1:0] lvl_q
);
    localparam int PAD = RW - CH;

    // Register update: reset values, then addressed write of implemented bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '1;
            lvl_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_SEL) sel_q <= wr_data[CH-1:0];
            else                     lvl_q <= wr_data[CH-1:0];
        end
    end

    // Read mux with zero padding above the implemented field.
    always_comb begin
        rd_data = {{PAD{1'b0}}, (rd_addr == ADDR_SEL) ? sel_q : lvl_q};
    end
endmodule

// File: rtl/pwm_ovr_pair.sv
// Module: resolves one even/odd channel pair, combinational.
// Assumes comp forces even = ~odd; otherwise each channel picks alone.
module pwm_ovr_pair (
    input  logic       comp,
    input  logic [1:0] sel,
    input  logic [1:0] lvl,
    input  logic [1:0] gen,
    output logic [1:0] nxt
);
    logic odd_v;
    logic even_v;

    // Per-channel source choice and complementary forcing of the even one.
    always_comb begin
        odd_v  = sel[1] ? gen[1] : lvl[1];
        even_v = sel[0] ? gen[0] : lvl[0];
        nxt    = {odd_v, comp ? ~odd_v : even_v};
    end
endmodule

// File: rtl/pwm_ovr_unit.sv
// Top: six-channel PWM override between generator and pins.
// Assumes outputs registered so both source paths have one-cycle latency.
module pwm_ovr_unit
    import pwm_ovr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              comp_mode,
    input  logic [NUM_CH-1:0] gen_pwm,
    output logic [NUM_CH-1:0] out_pwm
);
    ch_vec_t sel_q, lvl_q, nxt;

    pwm_ovr_regs #(.CH(NUM_CH), .RW(REG_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sel_q(sel_q), .lvl_q(lvl_q)
    );

    for (genvar k = 0; k < NUM_PAIR; k++) begin : g_pair
        pwm_ovr_pair i_pair (
            .comp(comp_mode),
            .sel(sel_q[2*k+1:2*k]),
            .lvl(lvl_q[2*k+1:2*k]),
            .gen(gen_pwm[2*k+1:2*k]),
            .nxt(nxt[2*k+1:2*k])
        );
    end

    // Output register: glitch-free pins, inactive until first edge out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) out_pwm <= '0;
        else        out_pwm <= nxt;
    end
endmodule

// File: rtl/pwm_ovr_chk.sv
// Checker: temporal properties of the override unit, bound to the top.
// Assumes read port observed through rd_addr; uses ports only.
module pwm_ovr_chk
    import pwm_ovr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_addr,
    input logic [REG_W-1:0]  wr_data,
    input logic              rd_addr,
    input logic [REG_W-1:0]  rd_data,
    input logic              comp_mode,
    input logic [NUM_CH-1:0] gen_pwm,
    input logic [NUM_CH-1:0] out_pwm
);
    logic seen;
    // Marks one full cycle out of reset so $past has valid history.
    always_ff @(posedge clk) seen <= rst_n;

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7:6] == 2'b00); // R4
    AST_COMP_PAIR0: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(comp_mode)) |-> out_pwm[0] == ~out_pwm[1]); // R6
    AST_COMP_PAIR1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(comp_mode)) |-> out_pwm[2] == ~out_pwm[3]); // R6
    AST_COMP_PAIR2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(comp_mode)) |-> out_pwm[4] == ~out_pwm[5]); // R6
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_addr == wr_addr) |=> (rd_addr != $past(wr_addr)) ||
        rd_data[5:0] == $past(wr_data[5:0])); // R4
endmodule

bind pwm_ovr_unit pwm_ovr_chk i_chk (.*);

// File: tb/test_pwm_ovr_unit.sv
module test_pwm_ovr_unit;
    logic       clk = 0, rst_n = 0, wr_en = 0, wr_addr = 0, rd_addr = 0, comp_mode = 0;
    logic [7:0] wr_data = 0, rd_data;
    logic [5:0] gen_pwm = 0, out_pwm;
    int n_chk = 0, n_ok = 0;
    logic [5:0] m_sel, m_lvl;

    pwm_ovr_unit i_pwm_ovr_unit (.*);

    always #10 clk = ~clk;

    initial begin
        #4_000_000;
        n_chk++;
        $display("FAIL watchdog: R7 act=timeout exp=finish");
        $display("%0d/%0d checks passed", n_ok, n_chk);
        $finish;
    end

    function automatic logic [5:0] predict(logic [5:0] s, logic [5:0] l,
                                           logic [5:0] g, logic c);
        logic [5:0] r;
        for (int i = 0; i < 6; i++) r[i] = s[i] ? g[i] : l[i];
        if (c) for (int k = 0; k < 3; k++) r[2*k] = ~r[2*k+1];
        return r;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act === exp) n_ok++;
        else $display("FAIL %s act=%h exp=%h", req, act, exp);
    endtask

    // one cycle: drive at negedge, clock, then check output after edge
    task automatic step(logic we, logic wa, logic [7:0] wd, logic [5:0] g,
                        logic c, string req);
        logic [5:0] exp;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; gen_pwm = g; comp_mode = c;
        exp = predict(m_sel, m_lvl, g, c);
        @(posedge clk);
        if (we) begin
            if (wa) m_lvl = wd[5:0]; else m_sel = wd[5:0];
        end
        #2;
        check(req, {2'b0, out_pwm}, {2'b0, exp});
    endtask

    task automatic rd(logic a, string req);
        @(negedge clk);
        wr_en = 0; rd_addr = a; #1;
        check(req, rd_data, {2'b0, a ? m_lvl : m_sel});
    endtask

    initial begin
        void'($urandom(32'd1234));
        m_sel = 6'h3F; m_lvl = 6'h00;
        repeat (3) @(posedge clk);
        #2;
        check("R1 out", {2'b0, out_pwm}, 8'h00);
        @(negedge clk); rst_n = 1;
        rd(0, "R1 sel"); rd(1, "R1 lvl");
        // R2 generator pass-through
        step(0, 0, 0, 6'h2A, 0, "R2");
        step(0, 0, 0, 6'h15, 0, "R2");
        // R4 upper bits ignored, R5 read
        step(1, 0, 8'hC0, 6'h3F, 0, "R4");
        rd(0, "R4 sel upper"); rd(1, "R5 lvl");
        step(1, 1, 8'hFF, 6'h00, 0, "R4");
        rd(1, "R4 lvl upper");
        // R3 manual levels; R7 next-edge effect
        step(1, 1, 8'h2D, 6'h3F, 0, "R3");
        step(0, 0, 0, 6'h3F, 0, "R7");
        // R6 even manual bits conflict
        step(1, 0, 8'h00, 6'h00, 1, "R6");
        step(1, 1, 8'h3F, 6'h00, 1, "R6");
        step(0, 0, 0, 6'h00, 1, "R6");
        step(1, 0, 8'h2A, 6'h15, 1, "R6");
        // random mixing of writes, generator and mode
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r = $urandom;
            step(r[0], r[1], r[15:8], r[21:16], r[2], "R2/R3/R6 random");
            if (r[3]) rd(r[4], "R5 random");
        end
        $display("%0d/%0d checks passed", n_ok, n_chk);
        $finish;
    end
endmodule